// File: doc/BRIEF.md
# Real-Time Counter with Periodic Bus Snapshot

This block keeps wall-clock time as a 32-bit seconds count and a sub-second milliseconds count. Both advance from a slow tick enable that stands for a 32 kHz oscillator inside the bus clock domain. The bus never reads the running counters directly. Once in every group of eight slow ticks, the block copies seconds and milliseconds together into a pair of bus-visible registers. A one-cycle busy flag marks the cycle in which that copy happens.

Software reads through a simple register port with address, data, read strobe and write strobe. Reads are served at all times. Writes to the time, alarm and countdown registers are dropped in the busy cycle, so software polls the busy register before it writes. Reading the milliseconds register stores the visible seconds in a shadow register. A later read of the shadow therefore returns the seconds that belong with the milliseconds already read.

Five event sources feed a sticky status register: two seconds alarms, one milliseconds alarm, a seconds countdown and a milliseconds countdown. A mask register selects which status bits drive the single interrupt line.

Top module: `rtc_shadow_timer`

## Requirements
- R1: After reset every register reads 0 and `irq_o` is 0.
- R2: Busy (address 0, bit 0) reads 1 for exactly the one cycle after every eighth tick since reset, and 0 at all other times. At the end of that cycle, the visible seconds and milliseconds both take the running values.
- R3: Reads are served in every cycle, busy or not. The address map is: 0 busy, 1 seconds, 2 shadow seconds, 3 milliseconds, 4 seconds alarm A, 5 seconds alarm B, 6 milliseconds alarm, 7 seconds countdown, 8 milliseconds countdown, 9 mask, 10 status. Any other address reads 0, and writes to address 0 have no effect.
- R4: A write to addresses 1 and 3 to 8 is ignored while busy reads 1. Writes to mask and status are always taken.
- R5: A read of address 3 copies the visible seconds into the shadow register at that clock edge. Without such a read, the shadow register keeps its value.
- R6: Status is write-1-to-clear. A 1 in write data clears that bit and a 0 leaves it unchanged. The bits are: 0 alarm A, 1 alarm B, 2 milliseconds alarm, 3 seconds countdown, 4 milliseconds countdown. Mask bits sit in the same positions.
- R7: Every 32 ticks advance the milliseconds by one. The count runs 0 to 999, and its wrap to 0 increments the seconds, which wrap modulo 2^32. A write to seconds or milliseconds updates both the running and the visible value. A milliseconds write also restarts the 32-tick phase. A milliseconds write of 1000 or more is ignored.
- R8: A status bit sets on its event whatever the mask. `irq_o` is 1 exactly when some status bit and its mask bit are both 1, and it follows the same clock edge as status and mask.
- R9: A seconds alarm sets its status bit when the seconds count advances to the alarm value. An alarm value of 0 disables it.
- R10: The milliseconds alarm sets bit 2 when the milliseconds count advances to its value. A value of 0 disables it.
- R11: A countdown loaded with N decrements once per second (seconds countdown) or once per millisecond (milliseconds countdown). It sets its status bit on the step from 1 to 0 and then stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Slow-oscillator tick enable, one bus cycle wide |
| bus_rd_i | input | 1 | Read strobe (matters only for the shadow capture) |
| bus_wr_i | input | 1 | Write strobe |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that the busy pulse lasts one cycle, always follows a tick and moves both time values together. They also check that an alarm write is dropped while busy, that the shadow register changes only on a milliseconds read, that write-1-to-clear and sticky status behave, that the milliseconds count stays below 1000, and that the interrupt matches status and mask. Only the bench scenarios show counting arithmetic across many ticks: the milliseconds wrap that moves the seconds, the seconds wrap past 2^32, alarm matches including the disabling value 0, and countdown expiry. They also show the address map and the dropping of out-of-range millisecond writes.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 32;
    localparam int NUM_SRC = 5;

    typedef enum logic [ADDR_W-1:0] {
        REG_BUSY   = 4'd0,
        REG_SEC    = 4'd1,
        REG_SHADOW = 4'd2,
        REG_MSEC   = 4'd3,
        REG_ALM0   = 4'd4,
        REG_ALM1   = 4'd5,
        REG_MALM   = 4'd6,
        REG_SCNT   = 4'd7,
        REG_MCNT   = 4'd8,
        REG_MASK   = 4'd9,
        REG_STAT   = 4'd10
    } reg_addr_e;

    // event source positions in mask and status
    localparam int SRC_ALM0 = 0;
    localparam int SRC_ALM1 = 1;
    localparam int SRC_MALM = 2;
    localparam int SRC_SCNT = 3;
    localparam int SRC_MCNT = 4;
endpackage

// File: rtl/rtc_timebase.sv
`timescale 1ns/1ps
// Running counters: tick prescaler, milliseconds, seconds and the copy cadence.
module rtc_timebase #(
    parameter int TICKS_PER_MS = 32,
    parameter int MS_PER_SEC   = 1000,
    parameter int COPY_TICKS   = 8,
    parameter int SEC_W        = 32
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          tick_i,
    input  logic                          sec_wr_i,
    input  logic [SEC_W-1:0]              sec_wdata_i,
    input  logic                          ms_wr_i,
    input  logic [$clog2(MS_PER_SEC)-1:0] ms_wdata_i,
    output logic [SEC_W-1:0]              sec_o,
    output logic [$clog2(MS_PER_SEC)-1:0] ms_o,
    output logic [SEC_W-1:0]              sec_nxt_o,
    output logic [$clog2(MS_PER_SEC)-1:0] ms_nxt_o,
    output logic                          sec_step_o,
    output logic                          ms_step_o,
    output logic                          copy_o
);
    localparam int PS_W = $clog2(TICKS_PER_MS);
    localparam int MS_W = $clog2(MS_PER_SEC);
    localparam int CP_W = $clog2(COPY_TICKS);

    typedef struct packed {
        logic [PS_W-1:0]  presc;
        logic [CP_W-1:0]  cpy;
        logic             copy;
        logic [MS_W-1:0]  ms;
        logic [SEC_W-1:0] sec;
    } tb_state_t;

    tb_state_t st_d, st_q;
    logic presc_last, ms_last, cpy_last;
    logic ms_step, sec_step;

    always_comb begin
        st_d       = st_q;
        ms_step    = 1'b0;
        sec_step   = 1'b0;
        presc_last = (st_q.presc == PS_W'(TICKS_PER_MS - 1));
        ms_last    = (st_q.ms == MS_W'(MS_PER_SEC - 1));
        cpy_last   = (st_q.cpy == CP_W'(COPY_TICKS - 1));
        st_d.copy  = tick_i && cpy_last;
        if (tick_i) begin
            st_d.cpy   = cpy_last ? '0 : st_q.cpy + 1'b1;
            st_d.presc = presc_last ? '0 : st_q.presc + 1'b1;
            if (presc_last) begin
                ms_step = 1'b1;
                st_d.ms = ms_last ? '0 : st_q.ms + 1'b1;
                if (ms_last) begin
                    sec_step = 1'b1;
                    st_d.sec = st_q.sec + 1'b1;
                end
            end
        end
        if (ms_wr_i) begin
            st_d.ms    = ms_wdata_i;
            st_d.presc = '0;
            st_d.sec   = st_q.sec;
            ms_step    = 1'b0;
            sec_step   = 1'b0;
        end
        if (sec_wr_i) begin
            st_d.sec = sec_wdata_i;
            sec_step = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign sec_o      = st_q.sec;
    assign ms_o       = st_q.ms;
    assign sec_nxt_o  = st_d.sec;
    assign ms_nxt_o   = st_d.ms;
    assign sec_step_o = sec_step;
    assign ms_step_o  = ms_step;
    assign copy_o     = st_q.copy;
endmodule

// File: rtl/rtc_alarm_unit.sv
`timescale 1ns/1ps
// Alarm and countdown registers with their event detection.
module rtc_alarm_unit import rtc_pkg::*; #(
    parameter int SEC_W = 32,
    parameter int MS_W  = 10,
    parameter int CNT_W = 32
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] wr_sel_i,
    input  logic [SEC_W-1:0]   wdata_i,
    input  logic               sec_step_i,
    input  logic [SEC_W-1:0]   sec_nxt_i,
    input  logic               ms_step_i,
    input  logic [MS_W-1:0]    ms_nxt_i,
    output logic [SEC_W-1:0]   alm0_o,
    output logic [SEC_W-1:0]   alm1_o,
    output logic [MS_W-1:0]    malm_o,
    output logic [CNT_W-1:0]   scnt_o,
    output logic [CNT_W-1:0]   mcnt_o,
    output logic [NUM_SRC-1:0] ev_o
);
    localparam int NUM_SALM = 2;

    typedef struct packed {
        logic [NUM_SALM-1:0][SEC_W-1:0] alm;
        logic [MS_W-1:0]                malm;
        logic [CNT_W-1:0]               scnt;
        logic [CNT_W-1:0]               mcnt;
    } alm_state_t;

    alm_state_t st_d, st_q;
    logic [NUM_SALM-1:0] sec_hit;
    logic malm_hit, scnt_fire, mcnt_fire;

    for (genvar i = 0; i < NUM_SALM; i++) begin : g_sec_alarm
        assign sec_hit[i] = sec_step_i && (st_q.alm[i] != '0) && (sec_nxt_i == st_q.alm[i]);
    end

    always_comb begin
        st_d      = st_q;
        malm_hit  = ms_step_i && (st_q.malm != '0) && (ms_nxt_i == st_q.malm);
        scnt_fire = sec_step_i && !wr_sel_i[SRC_SCNT] && (st_q.scnt == CNT_W'(1));
        mcnt_fire = ms_step_i && !wr_sel_i[SRC_MCNT] && (st_q.mcnt == CNT_W'(1));
        for (int i = 0; i < NUM_SALM; i++) begin
            if (wr_sel_i[SRC_ALM0 + i]) st_d.alm[i] = wdata_i;
        end
        if (wr_sel_i[SRC_MALM]) st_d.malm = wdata_i[MS_W-1:0];
        if (wr_sel_i[SRC_SCNT])                       st_d.scnt = CNT_W'(wdata_i);
        else if (sec_step_i && st_q.scnt != '0)       st_d.scnt = st_q.scnt - 1'b1;
        if (wr_sel_i[SRC_MCNT])                       st_d.mcnt = CNT_W'(wdata_i);
        else if (ms_step_i && st_q.mcnt != '0)        st_d.mcnt = st_q.mcnt - 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign alm0_o = st_q.alm[0];
    assign alm1_o = st_q.alm[1];
    assign malm_o = st_q.malm;
    assign scnt_o = st_q.scnt;
    assign mcnt_o = st_q.mcnt;

    always_comb begin
        ev_o           = '0;
        ev_o[SRC_ALM0] = sec_hit[0];
        ev_o[SRC_ALM1] = sec_hit[1];
        ev_o[SRC_MALM] = malm_hit;
        ev_o[SRC_SCNT] = scnt_fire;
        ev_o[SRC_MCNT] = mcnt_fire;
    end
endmodule

// File: rtl/rtc_irq_ctrl.sv
`timescale 1ns/1ps
// Sticky status with write-1-to-clear, mask and registered interrupt line.
module rtc_irq_ctrl #(
    parameter int NSRC = 5
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [NSRC-1:0] ev_i,
    input  logic            mask_wr_i,
    input  logic            stat_wr_i,
    input  logic [NSRC-1:0] wdata_i,
    output logic [NSRC-1:0] mask_o,
    output logic [NSRC-1:0] stat_o,
    output logic            irq_o
);
    typedef struct packed {
        logic [NSRC-1:0] mask;
        logic [NSRC-1:0] stat;
        logic            irq;
    } irq_state_t;

    irq_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        if (mask_wr_i) st_d.mask = wdata_i;
        // a new event wins over a clear in the same cycle
        st_d.stat = (st_q.stat & ~(stat_wr_i ? wdata_i : '0)) | ev_i;
        st_d.irq  = |(st_d.stat & st_d.mask);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign mask_o = st_q.mask;
    assign stat_o = st_q.stat;
    assign irq_o  = st_q.irq;
endmodule

// File: rtl/rtc_shadow_timer.sv
`timescale 1ns/1ps
// Top: register decode, visible time pair, shadow seconds and read mux.
module rtc_shadow_timer import rtc_pkg::*; #(
    parameter int TICKS_PER_MS = 32,
    parameter int MS_PER_SEC   = 1000,
    parameter int COPY_TICKS   = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              bus_rd_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o
);
    localparam int MS_W  = $clog2(MS_PER_SEC);
    localparam int SEC_W = DATA_W;

    typedef struct packed {
        logic [SEC_W-1:0] vis_sec;
        logic [MS_W-1:0]  vis_ms;
        logic [SEC_W-1:0] shadow;
    } top_state_t;

    top_state_t top_d, top_q;

    logic               busy;
    logic               wr_ok;
    logic               sec_wr, ms_wr, mask_wr, stat_wr;
    logic [NUM_SRC-1:0] alm_wr;
    logic [SEC_W-1:0]   live_sec, sec_nxt, vis_sec, shadow;
    logic [MS_W-1:0]    live_ms, ms_nxt, vis_ms;
    logic               sec_step, ms_step;
    logic [SEC_W-1:0]   alm0, alm1, scnt, mcnt;
    logic [MS_W-1:0]    malm;
    logic [NUM_SRC-1:0] ev, mask, stat;

    // write decode: time and alarm writes are dropped in the copy cycle
    always_comb begin
        wr_ok            = bus_wr_i && !busy;
        sec_wr           = wr_ok && (bus_addr_i == REG_SEC);
        ms_wr            = wr_ok && (bus_addr_i == REG_MSEC) &&
                           (bus_wdata_i < DATA_W'(MS_PER_SEC));
        alm_wr           = '0;
        alm_wr[SRC_ALM0] = wr_ok && (bus_addr_i == REG_ALM0);
        alm_wr[SRC_ALM1] = wr_ok && (bus_addr_i == REG_ALM1);
        alm_wr[SRC_MALM] = wr_ok && (bus_addr_i == REG_MALM);
        alm_wr[SRC_SCNT] = wr_ok && (bus_addr_i == REG_SCNT);
        alm_wr[SRC_MCNT] = wr_ok && (bus_addr_i == REG_MCNT);
        mask_wr          = bus_wr_i && (bus_addr_i == REG_MASK);
        stat_wr          = bus_wr_i && (bus_addr_i == REG_STAT);
    end

    rtc_timebase #(
        .TICKS_PER_MS (TICKS_PER_MS),
        .MS_PER_SEC   (MS_PER_SEC),
        .COPY_TICKS   (COPY_TICKS),
        .SEC_W        (SEC_W)
    ) u_timebase (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .tick_i      (tick_i),
        .sec_wr_i    (sec_wr),
        .sec_wdata_i (bus_wdata_i),
        .ms_wr_i     (ms_wr),
        .ms_wdata_i  (bus_wdata_i[MS_W-1:0]),
        .sec_o       (live_sec),
        .ms_o        (live_ms),
        .sec_nxt_o   (sec_nxt),
        .ms_nxt_o    (ms_nxt),
        .sec_step_o  (sec_step),
        .ms_step_o   (ms_step),
        .copy_o      (busy)
    );

    rtc_alarm_unit #(
        .SEC_W (SEC_W),
        .MS_W  (MS_W),
        .CNT_W (SEC_W)
    ) u_alarm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_sel_i   (alm_wr),
        .wdata_i    (bus_wdata_i),
        .sec_step_i (sec_step),
        .sec_nxt_i  (sec_nxt),
        .ms_step_i  (ms_step),
        .ms_nxt_i   (ms_nxt),
        .alm0_o     (alm0),
        .alm1_o     (alm1),
        .malm_o     (malm),
        .scnt_o     (scnt),
        .mcnt_o     (mcnt),
        .ev_o       (ev)
    );

    rtc_irq_ctrl #(
        .NSRC (NUM_SRC)
    ) u_irq (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .ev_i      (ev),
        .mask_wr_i (mask_wr),
        .stat_wr_i (stat_wr),
        .wdata_i   (bus_wdata_i[NUM_SRC-1:0]),
        .mask_o    (mask),
        .stat_o    (stat),
        .irq_o     (irq_o)
    );

    // visible pair and shadow seconds
    always_comb begin
        top_d = top_q;
        if (busy) begin
            top_d.vis_sec = live_sec;
            top_d.vis_ms  = live_ms;
        end
        if (sec_wr) top_d.vis_sec = bus_wdata_i;
        if (ms_wr)  top_d.vis_ms  = bus_wdata_i[MS_W-1:0];
        if (bus_rd_i && (bus_addr_i == REG_MSEC)) top_d.shadow = top_q.vis_sec;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) top_q <= '0;
        else         top_q <= top_d;
    end

    assign vis_sec = top_q.vis_sec;
    assign vis_ms  = top_q.vis_ms;
    assign shadow  = top_q.shadow;

    always_comb begin
        case (bus_addr_i)
            REG_BUSY:   bus_rdata_o = DATA_W'(busy);
            REG_SEC:    bus_rdata_o = vis_sec;
            REG_SHADOW: bus_rdata_o = shadow;
            REG_MSEC:   bus_rdata_o = DATA_W'(vis_ms);
            REG_ALM0:   bus_rdata_o = alm0;
            REG_ALM1:   bus_rdata_o = alm1;
            REG_MALM:   bus_rdata_o = DATA_W'(malm);
            REG_SCNT:   bus_rdata_o = scnt;
            REG_MCNT:   bus_rdata_o = mcnt;
            REG_MASK:   bus_rdata_o = DATA_W'(mask);
            REG_STAT:   bus_rdata_o = DATA_W'(stat);
            default:    bus_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/rtc_shadow_timer_chk.sv
`timescale 1ns/1ps
module rtc_shadow_timer_chk import rtc_pkg::*; #(
    parameter int MS_PER_SEC = 1000,
    parameter int MS_W       = 10,
    parameter int SEC_W      = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick,
    input logic               bus_rd,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [NUM_SRC-1:0] wdata_lo,
    input logic               busy,
    input logic [SEC_W-1:0]   live_sec,
    input logic [MS_W-1:0]    live_ms,
    input logic [SEC_W-1:0]   vis_sec,
    input logic [MS_W-1:0]    vis_ms,
    input logic [SEC_W-1:0]   shadow,
    input logic [SEC_W-1:0]   alm0,
    input logic [NUM_SRC-1:0] stat,
    input logic [NUM_SRC-1:0] mask,
    input logic [NUM_SRC-1:0] ev,
    input logic               irq
);
    a_r2_busy_single: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    a_r2_busy_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $past(tick));

    a_r2_copy_pair: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (vis_sec == $past(live_sec)) && (vis_ms == $past(live_ms)));

    a_r4_alarm_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_wr && bus_addr == REG_ALM0) |=> $stable(alm0));

    a_r5_shadow_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == REG_MSEC) |=> (shadow == $past(vis_sec)));

    a_r5_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_addr == REG_MSEC) |=> $stable(shadow));

    a_r6_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_STAT) |=> ((stat & $past(wdata_lo) & ~$past(ev)) == '0));

    a_r8_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == REG_STAT) |=> ((stat & $past(stat)) == $past(stat)));

    a_r7_ms_range: assert property (@(posedge clk) disable iff (!rst_n)
        live_ms < MS_W'(MS_PER_SEC));

    a_r8_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        irq == |(stat & mask));
endmodule

bind rtc_shadow_timer rtc_shadow_timer_chk #(
    .MS_PER_SEC (MS_PER_SEC),
    .MS_W       (MS_W),
    .SEC_W      (SEC_W)
) u_chk (
    .clk      (clk_i),
    .rst_n    (rst_ni),
    .tick     (tick_i),
    .bus_rd   (bus_rd_i),
    .bus_wr   (bus_wr_i),
    .bus_addr (bus_addr_i),
    .wdata_lo (bus_wdata_i[4:0]),
    .busy     (busy),
    .live_sec (live_sec),
    .live_ms  (live_ms),
    .vis_sec  (vis_sec),
    .vis_ms   (vis_ms),
    .shadow   (shadow),
    .alm0     (alm0),
    .stat     (stat),
    .mask     (mask),
    .ev       (ev),
    .irq      (irq_o)
);

// File: tb/rtc_shadow_timer_bench.sv
`timescale 1ns/1ps
module rtc_shadow_timer_bench;
    import rtc_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] rv;

    always #2 clk = ~clk;

    rtc_shadow_timer u_rtc_shadow_timer (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .tick_i      (tick),
        .bus_rd_i    (bus_rd),
        .bus_wr_i    (bus_wr),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .irq_o       (irq)
    );

    // {address, write data, expected read-back}
    localparam int NVEC = 11;
    localparam logic [67:0] VECS [NVEC] = '{
        {4'd5,  32'h0000_1234, 32'h0000_1234},   // R3 alarm B
        {4'd6,  32'd500,       32'd500},         // R10 ms alarm value
        {4'd9,  32'hFFFF_FFFF, 32'h0000_001F},   // R6 mask width
        {4'd1,  32'hDEAD_BEEF, 32'hDEAD_BEEF},   // R7 seconds write
        {4'd3,  32'd999,       32'd999},         // R7 ms write
        {4'd3,  32'd1000,      32'd999},         // R7 out of range ignored
        {4'd7,  32'd9,         32'd9},           // R11 seconds countdown load
        {4'd8,  32'd0,         32'd0},           // R11 ms countdown idle
        {4'd4,  32'd0,         32'd0},           // R9 alarm A off
        {4'd9,  32'd0,         32'd0},           // R6 mask clear
        {4'd0,  32'd1,         32'd0}            // R3 busy not writable
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic run_ticks(input int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'd1, 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(REG_BUSY, rv); check("R1 busy", rv, 0);
        rd(REG_SEC,  rv); check("R1 seconds", rv, 0);
        rd(REG_MSEC, rv); check("R1 msec", rv, 0);
        rd(REG_STAT, rv); check("R1 status", rv, 0);
        check("R1 irq", {31'd0, irq}, 0);

        // R2 busy pulse on the eighth tick, R4 write in that cycle dropped
        tick = 1'b1;
        repeat (7) @(negedge clk);
        tick = 1'b0;
        bus_addr = REG_BUSY;
        #1 check("R2 busy before eighth tick", {31'd0, bus_rdata[0]}, 0);
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        bus_addr = REG_BUSY;
        #1 check("R2 busy after eighth tick", bus_rdata, 1);
        bus_addr = REG_ALM0; bus_wdata = 32'd55; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        bus_addr = REG_BUSY;
        #1 check("R2 busy one cycle", bus_rdata, 0);
        @(negedge clk);
        rd(REG_ALM0, rv); check("R4 write during busy ignored", rv, 0);
        wr(REG_ALM0, 32'd55);
        rd(REG_ALM0, rv); check("R4 write when idle taken", rv, 55);

        // table walk: register map and write rules
        for (int i = 0; i < NVEC; i++) begin
            wr(VECS[i][67:64], VECS[i][63:32]);
            rd(VECS[i][67:64], rv);
            check($sformatf("R3 table entry %0d", i), rv, VECS[i][31:0]);
        end
        rd(4'd15, rv); check("R3 unused address", rv, 0);

        // R5 shadow seconds
        wr(REG_SEC, 32'd77);
        rd(REG_SHADOW, rv); check("R5 shadow holds", rv, 32'hDEAD_BEEF);
        rd(REG_MSEC, rv);
        rd(REG_SHADOW, rv); check("R5 shadow captured", rv, 77);

        // R7 ms wrap into seconds, R9 alarm A, R8 irq
        wr(REG_MASK, 32'h01);
        wr(REG_ALM0, 32'd6);
        wr(REG_ALM1, 32'd9);
        wr(REG_SEC,  32'd5);
        wr(REG_MSEC, 32'd999);
        run_ticks(31);
        rd(REG_STAT, rv); check("R9 no alarm before wrap", rv, 0);
        run_ticks(1);
        rd(REG_STAT, rv); check("R9 alarm A on match", rv, 32'h01);
        check("R8 irq with mask", {31'd0, irq}, 1);
        run_ticks(8);
        rd(REG_SEC,  rv); check("R7 seconds after wrap", rv, 6);
        rd(REG_MSEC, rv); check("R2 copied ms after wrap", rv, 0);

        // R6 write-1-to-clear
        wr(REG_STAT, 32'h02);
        rd(REG_STAT, rv); check("R6 zero bits keep", rv, 32'h01);
        wr(REG_STAT, 32'h01);
        rd(REG_STAT, rv); check("R6 one bit clears", rv, 0);
        check("R6 irq drops", {31'd0, irq}, 0);

        // R10 ms alarm with mask off, R8 status regardless of mask
        wr(REG_MALM, 32'd3);
        wr(REG_MASK, 32'h00);
        wr(REG_MSEC, 32'd0);
        run_ticks(96);
        rd(REG_STAT, rv); check("R10 ms alarm", rv, 32'h04);
        check("R8 masked irq low", {31'd0, irq}, 0);
        wr(REG_MASK, 32'h04);
        check("R8 unmask raises irq", {31'd0, irq}, 1);
        wr(REG_STAT, 32'h04);

        // R9 alarm value 0 disabled, seconds wrap 2^32
        wr(REG_MALM, 32'd0);
        wr(REG_ALM0, 32'd0);
        wr(REG_MASK, 32'h1F);
        wr(REG_SEC,  32'hFFFF_FFFF);
        wr(REG_MSEC, 32'd999);
        run_ticks(40);
        rd(REG_STAT, rv); check("R9 zero alarm silent", rv, 0);
        rd(REG_SEC,  rv); check("R7 seconds wrap", rv, 0);

        // R9 alarm B
        wr(REG_ALM1, 32'd1);
        wr(REG_MSEC, 32'd999);
        run_ticks(32);
        rd(REG_STAT, rv); check("R9 alarm B", rv, 32'h02);
        check("R8 irq alarm B", {31'd0, irq}, 1);
        wr(REG_STAT, 32'h1F);

        // R11 seconds countdown
        wr(REG_SCNT, 32'd1);
        wr(REG_MSEC, 32'd999);
        run_ticks(32);
        rd(REG_STAT, rv); check("R11 seconds countdown", rv, 32'h08);
        rd(REG_SCNT, rv); check("R11 seconds countdown empty", rv, 0);
        wr(REG_STAT, 32'h1F);

        // R11 ms countdown
        wr(REG_MCNT, 32'd3);
        wr(REG_MSEC, 32'd0);
        run_ticks(95);
        rd(REG_STAT, rv); check("R11 ms countdown early", rv, 0);
        run_ticks(1);
        rd(REG_STAT, rv); check("R11 ms countdown fires", rv, 32'h10);
        rd(REG_MCNT, rv); check("R11 ms countdown empty", rv, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule